// File: doc/BRIEF.md
# Two-Level Interrupt Save/Restore Unit

This block holds the machine state register (MSR) of a processor core and two save/restore register pairs. One pair serves non-critical interrupts and the other serves critical interrupts. Each pair has a return-address register and a saved-state register. When an interrupt of either class is taken, the block stores the interrupted program's address and the current MSR into that class's pair, then clears the MSR. Each class has its own return request. A return reloads the MSR from the matching saved-state register and hands the saved return address to the fetch logic as a one-cycle pulse.

Software reaches all five registers through a special-purpose-register port. The port has a select code, a write enable and a combinational read-back. Unimplemented MSR bits and the two low bits of each return address are never stored, so they always read as zero. When several events arrive in one cycle, a fixed priority picks a single winner. A capture always beats a software write to the same register.

Top module: `irq_save_restore`

## Requirements
- R1: While `rst_ni` is low, the MSR and all four save/restore registers are zero, and `ret_valid_o` is low.
- R2: On the first clock edge where `crit_take_i` is high, the critical return-address register loads `take_pc_i` with bits [1:0] cleared. On the same edge the critical state register loads the MSR as it stood before that edge, and the MSR becomes zero.
- R3: A non-critical take (`nc_take_i`) does the same into the non-critical pair. The critical pair is left unchanged.
- R4: On the edge where a critical return (`crit_ret_i`) is the winning event, the MSR loads the critical state register. After that edge, `ret_valid_o` is high for one cycle and `ret_pc_o` equals the critical return address.
- R5: A non-critical return (`nc_ret_i`) does the same using the non-critical pair.
- R6: Only one event acts per cycle. The priority from highest to lowest is critical take, non-critical take, critical return, non-critical return. `ret_valid_o` is low after any edge where no return acted.
- R7: Select codes on `spr_sel_i` are: 0 MSR, 1 non-critical return address, 2 non-critical state, 3 critical return address, 4 critical state. With `spr_we_i` high, the selected register loads `spr_wdata_i` on the edge. `spr_rdata_o` shows the selected register combinationally.
- R8: Only the MSR bits set in mask 0x0006_FF30 (LSB = bit 0) are stored, in the MSR and in both state registers. Return-address bits [1:0] are never stored. All unstored bits read as zero.
- R9: If an event writes a register in the same cycle as a software write to it, the event's value wins. This covers a capture into either pair, and an MSR clear or restore. Software writes to other registers in that cycle still take effect.
- R10: Select codes 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| crit_take_i | input | 1 | Critical interrupt taken |
| nc_take_i | input | 1 | Non-critical interrupt taken |
| take_pc_i | input | 32 | Return address to capture on a take |
| crit_ret_i | input | 1 | Return from critical interrupt |
| nc_ret_i | input | 1 | Return from non-critical interrupt |
| spr_we_i | input | 1 | Software register write enable |
| spr_sel_i | input | 3 | Software register select |
| spr_wdata_i | input | 32 | Software write data |
| spr_rdata_o | output | 32 | Software read data (combinational) |
| msr_o | output | 32 | Current MSR |
| ret_valid_o | output | 1 | One-cycle pulse: a return address is offered |
| ret_pc_o | output | 32 | Returned address |

## Verification
Every event and write lands on the clock edge that samples it, so `msr_o`, `ret_valid_o` and `ret_pc_o` are due one edge after the inputs are driven. The driver applies inputs at the falling edge. It pushes the expected MSR and return pulse for the following rising edge, and the monitor pops and compares them a quarter period after that edge. Register read-back is combinational, so it is checked at a falling edge with no event or write pending. That moment sits between two rising edges, so it always observes the state left by the previous edge.

// File: rtl/isr_pkg.sv
`timescale 1ns/1ps
package isr_pkg;
  localparam int XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  // implemented MSR bits, LSB-numbered
  localparam word_t MSR_IMPL_MASK = 32'h0006_FF30;
  localparam int    PC_LSB_DROP   = 2;
  localparam word_t PC_MASK       = ~word_t'((1 << PC_LSB_DROP) - 1);

  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_MSR   = 3'd0,
    SEL_NC_PC = 3'd1,
    SEL_NC_ST = 3'd2,
    SEL_CR_PC = 3'd3,
    SEL_CR_ST = 3'd4
  } spr_sel_e;

  localparam int N_CLASS = 2;
  localparam int CLS_NC  = 0;
  localparam int CLS_CR  = 1;

  // event index = priority (0 highest)
  localparam int EV_CR_TAKE = 0;
  localparam int EV_NC_TAKE = 1;
  localparam int EV_CR_RET  = 2;
  localparam int EV_NC_RET  = 3;
  localparam int N_EV       = 4;
endpackage

// File: rtl/isr_event_arb.sv
`timescale 1ns/1ps
module isr_event_arb
  import isr_pkg::*;
(
  input  logic [N_EV-1:0] req_i,
  output logic [N_EV-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N_EV - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end

  always_comb begin
    assert_one_grant_R6: assert ($onehot0(gnt_o));
    assert_grant_needs_req_R6: assert ((gnt_o & ~req_i) == '0);
    assert_some_grant_R6: assert ((req_i == '0) || (gnt_o != '0));
  end
endmodule

// File: rtl/isr_save_pair.sv
`timescale 1ns/1ps
module isr_save_pair
  import isr_pkg::*;
#(
  parameter word_t ST_MASK = MSR_IMPL_MASK
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cap_i,
  input  word_t cap_pc_i,
  input  word_t cap_st_i,
  input  logic  pc_we_i,
  input  logic  st_we_i,
  input  word_t wdata_i,
  output word_t pc_o,
  output word_t st_o
);
  word_t pc_q, st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      st_q <= '0;
    end else if (cap_i) begin
      // capture overrides any software write this cycle
      pc_q <= cap_pc_i & PC_MASK;
      st_q <= cap_st_i & ST_MASK;
    end else begin
      if (pc_we_i) pc_q <= wdata_i & PC_MASK;
      if (st_we_i) st_q <= wdata_i & ST_MASK;
    end
  end

  assign pc_o = pc_q;
  assign st_o = st_q;

  // R2 / R3: capture stores the aligned address and the pre-clear state
  assert_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (pc_o == ($past(cap_pc_i) & PC_MASK)) && (st_o == ($past(cap_st_i) & ST_MASK)));
  // R3: pair holds when neither captured nor written
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_i && !pc_we_i && !st_we_i) |=> $stable(pc_o) && $stable(st_o));
  // R9: a write that collides with a capture is lost
  assert_cap_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && pc_we_i) |=> pc_o == ($past(cap_pc_i) & PC_MASK));
  assert_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_o[PC_LSB_DROP-1:0] == '0) && ((st_o & ~ST_MASK) == '0));
endmodule

// File: rtl/isr_msr_reg.sv
`timescale 1ns/1ps
module isr_msr_reg
  import isr_pkg::*;
#(
  parameter word_t MASK = MSR_IMPL_MASK
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  ld_i,
  input  word_t ld_val_i,
  input  logic  we_i,
  input  word_t wdata_i,
  output word_t msr_o
);
  word_t msr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    msr_q <= '0;
    else if (clr_i) msr_q <= '0;
    else if (ld_i)  msr_q <= ld_val_i & MASK;
    else if (we_i)  msr_q <= wdata_i & MASK;
  end

  assign msr_o = msr_q;

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> msr_o == '0);
  // R4 / R5 restore path
  assert_restore_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i) |=> msr_o == ($past(ld_val_i) & MASK));
  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_o & ~MASK) == '0);
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && !we_i) |=> $stable(msr_o));
endmodule

// File: rtl/irq_save_restore.sv
`timescale 1ns/1ps
module irq_save_restore
  import isr_pkg::*;
#(
  parameter word_t MSR_MASK = MSR_IMPL_MASK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             crit_take_i,
  input  logic             nc_take_i,
  input  logic [XLEN-1:0]  take_pc_i,
  input  logic             crit_ret_i,
  input  logic             nc_ret_i,
  input  logic             spr_we_i,
  input  logic [SEL_W-1:0] spr_sel_i,
  input  logic [XLEN-1:0]  spr_wdata_i,
  output logic [XLEN-1:0]  spr_rdata_o,
  output logic [XLEN-1:0]  msr_o,
  output logic             ret_valid_o,
  output logic [XLEN-1:0]  ret_pc_o
);
  logic [N_EV-1:0] ev_req, ev_gnt;
  word_t           msr;
  word_t           pc_r [N_CLASS];
  word_t           st_r [N_CLASS];
  logic            cap  [N_CLASS];
  logic            any_ret;
  word_t           ret_st, ret_pc_sel;
  logic            ret_valid_q;
  word_t           ret_pc_q;

  assign ev_req[EV_CR_TAKE] = crit_take_i;
  assign ev_req[EV_NC_TAKE] = nc_take_i;
  assign ev_req[EV_CR_RET]  = crit_ret_i;
  assign ev_req[EV_NC_RET]  = nc_ret_i;

  isr_event_arb i_arb (
    .req_i (ev_req),
    .gnt_o (ev_gnt)
  );

  assign cap[CLS_CR] = ev_gnt[EV_CR_TAKE];
  assign cap[CLS_NC] = ev_gnt[EV_NC_TAKE];
  assign any_ret     = ev_gnt[EV_CR_RET] | ev_gnt[EV_NC_RET];
  assign ret_st      = ev_gnt[EV_CR_RET] ? st_r[CLS_CR] : st_r[CLS_NC];
  assign ret_pc_sel  = ev_gnt[EV_CR_RET] ? pc_r[CLS_CR] : pc_r[CLS_NC];

  for (genvar g = 0; g < N_CLASS; g++) begin : g_pair
    localparam spr_sel_e PC_SEL = (g == CLS_CR) ? SEL_CR_PC : SEL_NC_PC;
    localparam spr_sel_e ST_SEL = (g == CLS_CR) ? SEL_CR_ST : SEL_NC_ST;
    logic pc_we, st_we;
    assign pc_we = spr_we_i && (spr_sel_i == PC_SEL);
    assign st_we = spr_we_i && (spr_sel_i == ST_SEL);

    isr_save_pair #(.ST_MASK(MSR_MASK)) i_pair (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cap_i    (cap[g]),
      .cap_pc_i (take_pc_i),
      .cap_st_i (msr),
      .pc_we_i  (pc_we),
      .st_we_i  (st_we),
      .wdata_i  (spr_wdata_i),
      .pc_o     (pc_r[g]),
      .st_o     (st_r[g])
    );
  end

  isr_msr_reg #(.MASK(MSR_MASK)) i_msr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cap[CLS_CR] | cap[CLS_NC]),
    .ld_i     (any_ret),
    .ld_val_i (ret_st),
    .we_i     (spr_we_i && (spr_sel_i == SEL_MSR)),
    .wdata_i  (spr_wdata_i),
    .msr_o    (msr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_valid_q <= 1'b0;
      ret_pc_q    <= '0;
    end else begin
      ret_valid_q <= any_ret;
      if (any_ret) ret_pc_q <= ret_pc_sel;
    end
  end

  always_comb begin
    unique case (spr_sel_i)
      SEL_MSR:   spr_rdata_o = msr;
      SEL_NC_PC: spr_rdata_o = pc_r[CLS_NC];
      SEL_NC_ST: spr_rdata_o = st_r[CLS_NC];
      SEL_CR_PC: spr_rdata_o = pc_r[CLS_CR];
      SEL_CR_ST: spr_rdata_o = st_r[CLS_CR];
      default:   spr_rdata_o = '0;
    endcase
  end

  assign msr_o       = msr;
  assign ret_valid_o = ret_valid_q;
  assign ret_pc_o    = ret_pc_q;

  assert_crit_ret_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_ret_i && !crit_take_i && !nc_take_i)
      |=> ret_valid_o && (ret_pc_o == $past(pc_r[CLS_CR])));
  assert_nc_ret_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nc_ret_i && !crit_ret_i && !crit_take_i && !nc_take_i)
      |=> ret_valid_o && (ret_pc_o == $past(pc_r[CLS_NC])));
  assert_no_ret_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_take_i || nc_take_i || (!crit_ret_i && !nc_ret_i)) |=> !ret_valid_o);
  assert_crit_over_nc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_take_i |=> $stable(pc_r[CLS_NC]) || $past(spr_we_i));
  assert_bad_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_sel_i > SEL_W'(SEL_CR_ST)) |-> spr_rdata_o == '0);
endmodule

// File: tb/test_irq_save_restore.sv
`timescale 1ns/1ps
module test_irq_save_restore;
  import isr_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       crit_take_i, nc_take_i, crit_ret_i, nc_ret_i, spr_we_i;
  word_t      take_pc_i, spr_wdata_i, spr_rdata_o, msr_o, ret_pc_o;
  logic [2:0] spr_sel_i;
  logic       ret_valid_o;

  always #10 clk_i = ~clk_i;

  irq_save_restore i_irq_save_restore (
    .clk_i, .rst_ni, .crit_take_i, .nc_take_i, .take_pc_i, .crit_ret_i, .nc_ret_i,
    .spr_we_i, .spr_sel_i, .spr_wdata_i, .spr_rdata_o, .msr_o, .ret_valid_o, .ret_pc_o
  );

  localparam word_t M_MSR = 32'h0006_FF30;  // R8 stored MSR bits
  localparam word_t M_PC  = 32'hFFFF_FFFC;  // R8 address bits

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic  vld;
    word_t pc;
    word_t msr;
    string req;
  } exp_t;
  exp_t exq[$];

  // reference state
  word_t m_msr, m_ncpc, m_ncst, m_crpc, m_crst;

  task automatic chk(input string req, input word_t act, input word_t exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: results are due one rising edge after the driver's falling edge
  always @(posedge clk_i) begin
    #5;
    if (rst_ni && exq.size() > 0) begin
      exp_t e;
      e = exq.pop_front();
      chk({e.req, " ret_valid"}, word_t'(ret_valid_o), word_t'(e.vld));
      chk({e.req, " msr"}, msr_o, e.msr);
      if (e.vld) chk({e.req, " ret_pc"}, ret_pc_o, e.pc);
    end
  end

  task automatic step(input bit ct, input bit nt, input bit crt, input bit nrt,
                      input word_t pc, input bit we, input logic [2:0] sel,
                      input word_t wd, input string req);
    exp_t e;
    bit any_ev, cr_cap, nc_cap;
    @(negedge clk_i);
    crit_take_i = ct; nc_take_i = nt; crit_ret_i = crt; nc_ret_i = nrt;
    take_pc_i = pc; spr_we_i = we; spr_sel_i = sel; spr_wdata_i = wd;
    e.vld = 0; e.pc = '0; e.req = req;
    any_ev = ct | nt | crt | nrt;
    cr_cap = ct;
    nc_cap = nt & !ct;
    if (ct) begin
      m_crpc = pc & M_PC; m_crst = m_msr; m_msr = '0;
    end else if (nt) begin
      m_ncpc = pc & M_PC; m_ncst = m_msr; m_msr = '0;
    end else if (crt) begin
      e.vld = 1; e.pc = m_crpc; m_msr = m_crst;
    end else if (nrt) begin
      e.vld = 1; e.pc = m_ncpc; m_msr = m_ncst;
    end
    if (we) begin
      case (sel)
        3'd0: if (!any_ev) m_msr  = wd & M_MSR;
        3'd1: if (!nc_cap) m_ncpc = wd & M_PC;
        3'd2: if (!nc_cap) m_ncst = wd & M_MSR;
        3'd3: if (!cr_cap) m_crpc = wd & M_PC;
        3'd4: if (!cr_cap) m_crst = wd & M_MSR;
        default: ;
      endcase
    end
    e.msr = m_msr;
    exq.push_back(e);
  endtask

  task automatic rd(input logic [2:0] sel, input word_t exp, input string req);
    @(negedge clk_i);
    crit_take_i = 0; nc_take_i = 0; crit_ret_i = 0; nc_ret_i = 0; spr_we_i = 0;
    spr_sel_i = sel;
    #1;
    chk({req, " readback"}, spr_rdata_o, exp);
  endtask

  task automatic rd_all(input string req);
    rd(3'd0, m_msr,  req);
    rd(3'd1, m_ncpc, req);
    rd(3'd2, m_ncst, req);
    rd(3'd3, m_crpc, req);
    rd(3'd4, m_crst, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    word_t lfsr;
    rst_ni = 0;
    crit_take_i = 0; nc_take_i = 0; crit_ret_i = 0; nc_ret_i = 0;
    spr_we_i = 0; spr_sel_i = '0; take_pc_i = '0; spr_wdata_i = '0;
    m_msr = '0; m_ncpc = '0; m_ncst = '0; m_crpc = '0; m_crst = '0;
    repeat (3) @(posedge clk_i);
    #5;
    chk("R1 ret_valid", word_t'(ret_valid_o), '0);
    chk("R1 msr", msr_o, '0);
    @(negedge clk_i);
    rst_ni = 1;
    rd_all("R1");

    // R7 / R8 writes and masking
    step(0,0,0,0, '0, 1, 3'd0, 32'hFFFF_FFFF, "R8");
    rd(3'd0, 32'h0006_FF30, "R8 msr mask");
    step(0,0,0,0, '0, 1, 3'd1, 32'h1234_5677, "R8");
    rd(3'd1, 32'h1234_5674, "R8 pc align");
    step(0,0,0,0, '0, 1, 3'd2, 32'hFFFF_FFFF, "R7");
    step(0,0,0,0, '0, 1, 3'd3, 32'hDEAD_BEEF, "R7");
    step(0,0,0,0, '0, 1, 3'd4, 32'h0000_FFFF, "R7");
    rd_all("R7");

    // R3 non-critical take, critical pair untouched
    step(0,0,0,0, '0, 1, 3'd0, 32'h0002_8010, "R7");
    step(0,1,0,0, 32'h4000_0102, 0, 3'd0, '0, "R3");
    rd_all("R3");
    // R2 critical take while nested
    step(0,0,0,0, '0, 1, 3'd0, 32'h0000_1230, "R7");
    step(1,0,0,0, 32'h8000_0007, 0, 3'd0, '0, "R2");
    rd_all("R2");
    step(0,0,1,0, '0, 0, 3'd0, '0, "R4");
    step(0,0,0,0, '0, 0, 3'd0, '0, "R4 pulse ends");
    step(0,0,0,1, '0, 0, 3'd0, '0, "R5");
    step(0,0,0,0, '0, 0, 3'd0, '0, "R5 pulse ends");
    rd_all("R5");

    // R6 priority
    step(0,0,0,0, '0, 1, 3'd0, 32'h0004_0000, "R7");
    step(1,1,1,1, 32'h0000_0ABC, 0, 3'd0, '0, "R6 all");
    rd_all("R6");
    step(0,1,1,0, 32'h0000_1111, 0, 3'd0, '0, "R6 nc take over ret");
    rd_all("R6");
    step(0,0,1,1, '0, 0, 3'd0, '0, "R6 crit ret over nc ret");
    step(0,0,1,0, '0, 0, 3'd0, '0, "R6 back to back ret");

    // R9 collisions
    step(0,0,0,0, '0, 1, 3'd0, 32'h0000_0F00, "R7");
    step(1,0,0,0, 32'h2000_0004, 1, 3'd3, 32'h1111_1110, "R9 crit pc");
    rd_all("R9");
    step(0,1,0,0, 32'h3000_0008, 1, 3'd0, 32'h0006_0000, "R9 msr");
    step(1,0,0,0, 32'h3000_0010, 1, 3'd2, 32'h0000_0100, "R9 other reg");
    rd_all("R9");
    step(0,0,1,0, '0, 1, 3'd0, 32'h0000_0030, "R9 restore");

    // R10 unused selects
    step(0,0,0,0, '0, 1, 3'd5, 32'hFFFF_FFFF, "R10");
    step(0,0,0,0, '0, 1, 3'd7, 32'hFFFF_FFFF, "R10");
    rd(3'd5, '0, "R10");
    rd(3'd6, '0, "R10");
    rd(3'd7, '0, "R10");
    rd_all("R10");

    // mixed traffic
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[3] & lfsr[9], lfsr[4] & lfsr[10], lfsr[5], lfsr[6], lfsr ^ 32'h5A5A_0F0F,
           lfsr[7], lfsr[2:0], {lfsr[15:0], lfsr[31:16]}, "R6 mixed");
      if (i % 10 == 9) rd_all("R7 mixed");
    end
    step(0,0,0,0, '0, 0, 3'd0, '0, "R6 idle");
    @(negedge clk_i);
    @(negedge clk_i);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule